// File: doc/BRIEF.md
# Programmable Chip-Select Bus Controller

This block sits between a CPU's internal bus and an external memory bus. It compares the upper bits of each 24-bit CPU address against six programmable region bases and drives at most one of six active-low chip selects. It also runs the external write, read and byte-lane strobes for the access. Each region has its own enable, base, data width (8 or 16 bits) and wait-state count. A 16-bit access to an 8-bit region is split into two byte cycles on the low data lane.

At power-up only the boot region (slot 0, based at address 0) is live, and its width comes from a shared strap/wait pin. Software can then move or resize slots through a small configuration write port. Software can also exchange the pins of slots 0 and 1, so that a second device answers at address 0.

Top module: `cs_bus_ctrl`

## Requirements
- R1: After reset, slot 0 is enabled with base 0 and 15 wait states (a boot read strobes for 16 cycles on cs_n_o[0]), slots 1 to 5 are disabled, the swap is off, and every strobe and select output is high with ready_o low.
- R2: The level of wait_size_i at the first clock edge after rst_ni rises sets the boot width of slot 0 (1 = 16-bit, 0 = 8-bit). This width holds until the first configuration write to slot 0.
- R3: A configuration write with cfg_sel_i = 0..5 loads that slot as follows: bits [3:0] hold the wait states, bit 4 selects the 16-bit width, bit 5 is the enable, and bits [11:8] hold the base, compared with address bits [23:20]. A write with cfg_sel_i = 6 loads the swap flag from bit 0.
- R4: An enabled slot matches when address bits [23:20] equal its base. The lowest-numbered matching slot wins, and at most one cs_n_o bit is low, and only while a strobe is active.
- R5: An address with no matching enabled slot still runs one strobe cycle with no select asserted and completes. A read of it returns FFFFh.
- R6: While the swap flag is 1, slot 0's region drives cs_n_o[1] and slot 1's region drives cs_n_o[0]. Slots 2 to 5 keep their own pins.
- R7: we_n_o is low only during the strobe of a write, and oe_n_o is low only during the strobe of a read. The two are never low together.
- R8: A strobe lasts wait states + 1 cycles, and it is extended while wait_i is high once that count has elapsed. ready_o is high for exactly the one cycle after the last strobe cycle. req_i is held until then.
- R9: In a 16-bit region, ble_n_o follows be_i[0] and bhe_n_o follows be_i[1], ext_addr_o bit 0 is 0, and ext_data_o carries wdata_i unchanged.
- R10: In an 8-bit region with be_i = 11, two strobes run, separated by one idle cycle. The first is at the even address with the low byte and the second at the address + 1 with the high byte. Both use only ble_n_o and data lane [7:0], and the read bytes are assembled as {second, first}.
- R11: Read-data bytes whose byte enable is 0 return 00h for mapped regions.
- R12: In an 8-bit region, an access with be_i = 10 runs a single strobe at the odd address on lane [7:0], and the byte read is returned in rdata_o[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address; bit 0 is ignored and be_i selects the bytes |
| be_i | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| wdata_i | input | 16 | Write data, even byte in [7:0] |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ready_o |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Slot 0 to 5, or 6 for the swap flag |
| cfg_wdata_i | input | 16 | Configuration data |
| ext_addr_o | output | 24 | External address |
| ext_data_i | input | 16 | External read data |
| ext_data_o | output | 16 | External write data |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Read strobe, active low |
| ble_n_o | output | 1 | Low byte lane enable, active low |
| bhe_n_o | output | 1 | High byte lane enable, active low |
| cs_n_o | output | 6 | Chip selects, active low |
| wait_size_i | input | 1 | Boot-width strap after reset, then the wait input |

## Verification
The request is accepted on the first clock edge after req_i rises. Strobes appear in the next cycle and last wait states + 1 cycles, with one idle cycle between the halves of a split access, and ready_o follows in the cycle after the last strobe cycle. The bench samples every output at the falling clock edge and records each strobe run as a phase with its address, select, lanes, data and length. It then compares those lengths, the gap between phases and the data against values worked out from the slot settings. wait_i is released at a chosen strobe cycle, so the extension can be checked exactly, both after the count and within it.

// File: rtl/cs_bus_pkg.sv
package cs_bus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_TURN} bus_state_e;

  // configuration word field positions
  localparam int unsigned F_WS_LSB   = 0;
  localparam int unsigned F_W16      = 4;
  localparam int unsigned F_EN       = 5;
  localparam int unsigned F_BASE_LSB = 8;
  localparam int unsigned F_SWAP     = 0;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_bus_pkg::*;
#(
  parameter int unsigned N_CS   = 6,
  parameter int unsigned WS_W   = 4,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CFG_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        boot_size_i,
  input  logic                        cfg_we_i,
  input  logic [SEL_W-1:0]            cfg_sel_i,
  input  logic [CFG_W-1:0]            cfg_wdata_i,
  output logic [N_CS-1:0]             en_o,
  output logic [N_CS-1:0]             w16_o,
  output logic [N_CS-1:0][WS_W-1:0]   ws_o,
  output logic [N_CS-1:0][BASE_W-1:0] base_o,
  output logic                        swap_o
);
  logic strap_done_q, boot16_q, swap_q;
  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata_i;

  // strap latched once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      boot16_q     <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      boot16_q     <= boot_size_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swap_q <= 1'b0;
    else if (cfg_we_i && cfg_sel_i == SEL_W'(N_CS)) swap_q <= cfg_wdata_i[F_SWAP];
  end
  assign swap_o = swap_q;

  for (genvar i = 0; i < N_CS; i++) begin : g_slot
    logic              en_q, w16_q, wr;
    logic [WS_W-1:0]   ws_q;
    logic [BASE_W-1:0] base_q;

    assign wr = cfg_we_i && (cfg_sel_i == SEL_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'(i == 0);
        ws_q   <= {WS_W{1'(i == 0)}};
        base_q <= '0;
        w16_q  <= 1'b0;
      end else if (wr) begin
        en_q   <= cfg_wdata_i[F_EN];
        w16_q  <= cfg_wdata_i[F_W16];
        ws_q   <= cfg_wdata_i[F_WS_LSB +: WS_W];
        base_q <= cfg_wdata_i[F_BASE_LSB +: BASE_W];
      end
    end

    if (i == 0) begin : g_boot
      logic set_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) set_q <= 1'b0;
        else if (wr) set_q <= 1'b1;
      end
      assign w16_o[i] = set_q ? w16_q : boot16_q;
    end else begin : g_plain
      assign w16_o[i] = w16_q;
    end

    assign en_o[i]   = en_q;
    assign ws_o[i]   = ws_q;
    assign base_o[i] = base_q;
  end
endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode #(
  parameter int unsigned N_CS   = 6,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned IDX_W  = $clog2(N_CS)
) (
  input  logic [BASE_W-1:0]           region_i,
  input  logic [N_CS-1:0]             en_i,
  input  logic [N_CS-1:0][BASE_W-1:0] base_i,
  input  logic                        swap_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            slot_o,
  output logic [N_CS-1:0]             pin_oh_o
);
  logic [N_CS-1:0]  match;
  logic [IDX_W-1:0] pin_idx;

  for (genvar i = 0; i < N_CS; i++) begin : g_match
    assign match[i] = en_i[i] && (region_i == base_i[i]);
  end

  // lowest slot wins
  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        slot_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pin_idx = slot_o;
    if (swap_i && slot_o <= IDX_W'(1)) pin_idx = slot_o ^ IDX_W'(1);
    pin_oh_o = hit_o ? (N_CS'(1) << pin_idx) : '0;
  end
endmodule

// File: rtl/cs_bus_seq.sv
module cs_bus_seq
  import cs_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_CS   = 6,
  parameter int unsigned WS_W   = 4,
  localparam int unsigned DATA_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              hit_i,
  input  logic [N_CS-1:0]   pin_oh_i,
  input  logic              w16_i,
  input  logic [WS_W-1:0]   ws_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic [N_CS-1:0]   cs_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              ble_n_o,
  output logic              bhe_n_o
);
  bus_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        be_q;
  logic [N_CS-1:0]   pin_q;
  logic [WS_W-1:0]   ws_q, cnt_q;
  logic              we_q, hit_q, narrow_q, two_q, odd_q, ready_q, act;
  logic              unused_a0;
  assign unused_a0 = addr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      be_q     <= '0;
      pin_q    <= '0;
      ws_q     <= '0;
      cnt_q    <= '0;
      we_q     <= 1'b0;
      hit_q    <= 1'b0;
      narrow_q <= 1'b0;
      two_q    <= 1'b0;
      odd_q    <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i && !ready_q) begin
          addr_q   <= addr_i;
          we_q     <= we_i;
          be_q     <= be_i;
          wdata_q  <= wdata_i;
          hit_q    <= hit_i;
          pin_q    <= pin_oh_i;
          narrow_q <= hit_i && !w16_i;
          two_q    <= hit_i && !w16_i && (be_i == 2'b11);
          odd_q    <= hit_i && !w16_i && (be_i == 2'b10);
          ws_q     <= hit_i ? ws_i : '0;
          cnt_q    <= hit_i ? ws_i : '0;
          rdata_q  <= hit_i ? '0 : '1;
          state_q  <= ST_ACT;
        end
        ST_ACT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!wait_i) begin
            if (hit_q) begin
              if (narrow_q) begin
                if (odd_q) rdata_q[DATA_W-1 -: BYTE_W] <= ext_data_i[BYTE_W-1:0];
                else       rdata_q[BYTE_W-1:0]         <= ext_data_i[BYTE_W-1:0];
              end else begin
                rdata_q <= {be_q[1] ? ext_data_i[DATA_W-1 -: BYTE_W] : {BYTE_W{1'b0}},
                            be_q[0] ? ext_data_i[BYTE_W-1:0]         : {BYTE_W{1'b0}}};
              end
            end
            if (two_q && !odd_q) begin
              odd_q   <= 1'b1;
              cnt_q   <= ws_q;
              state_q <= ST_TURN;
            end else begin
              ready_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_TURN: state_q <= ST_ACT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign act        = (state_q == ST_ACT);
  assign ready_o    = ready_q;
  assign rdata_o    = rdata_q;
  assign cs_n_o     = ~((act && hit_q) ? pin_q : '0);
  assign we_n_o     = !(act && we_q);
  assign oe_n_o     = !(act && !we_q);
  assign ble_n_o    = !(act && (narrow_q || be_q[0]));
  assign bhe_n_o    = !(act && !narrow_q && be_q[1]);
  assign ext_addr_o = {addr_q[ADDR_W-1:1], narrow_q && odd_q};
  assign ext_data_o = narrow_q
                    ? {wdata_q[DATA_W-1 -: BYTE_W], odd_q ? wdata_q[DATA_W-1 -: BYTE_W] : wdata_q[BYTE_W-1:0]}
                    : wdata_q;

  AST_WS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cnt_q != '0) |=> (state_q == ST_ACT)); // R8
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && wait_i) |=> (state_q == ST_ACT)); // R8
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R8
  AST_SECOND_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |=> (act && ext_addr_o[0] && bhe_n_o)); // R10
endmodule

// File: rtl/cs_bus_ctrl.sv
module cs_bus_ctrl #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned N_CS      = 6,
  parameter int unsigned WS_W      = 4,
  parameter int unsigned REGION_W  = 20,
  parameter int unsigned CFG_SEL_W = 3,
  parameter int unsigned CFG_W     = 16,
  localparam int unsigned DATA_W   = 2 * BYTE_W,
  localparam int unsigned BASE_W   = ADDR_W - REGION_W,
  localparam int unsigned IDX_W    = $clog2(N_CS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 ready_o,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 cfg_we_i,
  input  logic [CFG_SEL_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  output logic [ADDR_W-1:0]    ext_addr_o,
  input  logic [DATA_W-1:0]    ext_data_i,
  output logic [DATA_W-1:0]    ext_data_o,
  output logic                 we_n_o,
  output logic                 oe_n_o,
  output logic                 ble_n_o,
  output logic                 bhe_n_o,
  output logic [N_CS-1:0]      cs_n_o,
  input  logic                 wait_size_i
);
  logic [N_CS-1:0]             en, w16, pin_oh;
  logic [N_CS-1:0][WS_W-1:0]   ws;
  logic [N_CS-1:0][BASE_W-1:0] base;
  logic                        swap, hit;
  logic [IDX_W-1:0]            slot;

  cs_cfg_regs #(
    .N_CS(N_CS), .WS_W(WS_W), .BASE_W(BASE_W), .SEL_W(CFG_SEL_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .boot_size_i (wait_size_i),
    .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .en_o (en), .w16_o (w16), .ws_o (ws), .base_o (base), .swap_o (swap)
  );

  cs_addr_decode #(.N_CS(N_CS), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_dec (
    .region_i (addr_i[ADDR_W-1 -: BASE_W]),
    .en_i     (en),
    .base_i   (base),
    .swap_i   (swap),
    .hit_o    (hit),
    .slot_o   (slot),
    .pin_oh_o (pin_oh)
  );

  cs_bus_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_CS(N_CS), .WS_W(WS_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .wait_i     (wait_size_i),
    .ext_data_i,
    .hit_i      (hit),
    .pin_oh_i   (pin_oh),
    .w16_i      (w16[slot]),
    .ws_i       (ws[slot]),
    .ready_o, .rdata_o, .ext_addr_o, .ext_data_o,
    .cs_n_o, .we_n_o, .oe_n_o, .ble_n_o, .bhe_n_o
  );

  AST_CS_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o)); // R7
  AST_CS_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o != '1) |-> (!we_n_o || !oe_n_o)); // R4
endmodule

// File: tb/cs_bus_ctrl_bench.sv
module cs_bus_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ready_o;
  logic [15:0] rdata_o;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [23:0] ext_addr_o;
  logic [15:0] ext_data_i, ext_data_o;
  logic        we_n_o, oe_n_o, ble_n_o, bhe_n_o;
  logic [5:0]  cs_n_o;
  logic        wait_size_i = 1'b1;

  always #10 clk_i = ~clk_i;

  cs_bus_ctrl u_cs_bus_ctrl (.*);

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'h3C};
  endfunction
  assign ext_data_i = mem_word(ext_addr_o);

  int n_chk = 0, n_bad = 0;
  int ph_n, gap;
  int ph_len[2];
  logic [23:0] ph_addr[2];
  logic [5:0]  ph_cs[2];
  logic        ph_ble[2], ph_bhe[2], ph_we[2], ph_oe[2];
  logic [15:0] ph_dout[2];
  logic [15:0] rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic size);
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0; wait_size_i = size;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    wait_size_i = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = s; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic access(input logic w, input logic [23:0] a, input logic [1:0] b,
                        input logic [15:0] d, input int wait_until);
    bit done = 0, prev = 0, act;
    int scnt = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; be_i = b; wdata_i = d;
    wait_size_i = (wait_until > 0);
    ph_n = 0; gap = 0; rd = 'x;
    for (int k = 0; k < 300 && !done; k++) begin
      @(negedge clk_i);
      if (ready_o) begin
        rd = rdata_o; req_i = 1'b0; done = 1;
      end else begin
        act = !we_n_o || !oe_n_o;
        if (act) begin
          if (!prev && ph_n < 2) begin
            ph_addr[ph_n] = ext_addr_o; ph_cs[ph_n] = ~cs_n_o;
            ph_ble[ph_n] = ble_n_o; ph_bhe[ph_n] = bhe_n_o;
            ph_we[ph_n] = we_n_o; ph_oe[ph_n] = oe_n_o;
            ph_dout[ph_n] = ext_data_o; ph_len[ph_n] = 0;
            ph_n++;
          end
          ph_len[ph_n-1]++;
          scnt++;
          if (scnt >= wait_until) wait_size_i = 1'b0;
        end else if (ph_n == 1) begin
          gap++;
        end
        prev = act;
      end
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL access hang (R8) actual=no ready expected=ready");
      req_i = 1'b0; wait_size_i = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk("R1 cs idle", cs_n_o, 6'h3F);
    chk("R1 strobes idle", {we_n_o, oe_n_o, ble_n_o, bhe_n_o}, 4'hF);
    chk("R1 ready low", ready_o, 0);
  endtask

  task automatic t_boot_read();
    access(0, 24'h000100, 2'b11, 0, 0);
    chk("R1 boot phases", ph_n, 1);
    chk("R1 boot pin", ph_cs[0], 6'h01);
    chk("R1 boot 15 ws length", ph_len[0], 16);
    chk("R7 read strobes", {ph_we[0], ph_oe[0]}, 2'b10);
    chk("R9 both lanes", {ph_ble[0], ph_bhe[0]}, 2'b00);
    chk("R2 16-bit boot data", rd, mem_word(24'h000100));
  endtask

  task automatic t_unmapped();
    access(0, 24'h300004, 2'b11, 0, 0);
    chk("R5 no select", ph_cs[0], 6'h00);
    chk("R5 one cycle", ph_len[0], 1);
    chk("R5 ones", rd, 16'hFFFF);
  endtask

  task automatic t_slot1_byte();
    cfg(3'd1, 16'h0332);
    access(0, 24'h300010, 2'b01, 0, 0);
    chk("R3 R4 slot1 pin", ph_cs[0], 6'h02);
    chk("R8 ws2 length", ph_len[0], 3);
    chk("R9 low lane only", {ph_ble[0], ph_bhe[0]}, 2'b01);
    chk("R11 masked byte", rd, {8'h00, mem_word(24'h300010) & 16'h00FF});
  endtask

  task automatic t_slot1_write();
    access(1, 24'h300020, 2'b11, 16'hBEEF, 0);
    chk("R7 write strobes", {ph_we[0], ph_oe[0]}, 2'b01);
    chk("R9 write data", ph_dout[0], 16'hBEEF);
    chk("R9 addr even", ph_addr[0], 24'h300020);
    chk("R9 lanes", {ph_ble[0], ph_bhe[0]}, 2'b00);
  endtask

  task automatic t_priority();
    cfg(3'd2, 16'h0330);
    access(0, 24'h300000, 2'b11, 0, 0);
    chk("R4 lowest wins pin", ph_cs[0], 6'h02);
    chk("R4 lowest wins timing", ph_len[0], 3);
  endtask

  task automatic t_narrow();
    cfg(3'd2, 16'h0521);
    access(0, 24'h500040, 2'b11, 0, 0);
    chk("R10 two phases", ph_n, 2);
    chk("R10 addr first", ph_addr[0], 24'h500040);
    chk("R10 addr second", ph_addr[1], 24'h500041);
    chk("R10 gap", gap, 1);
    chk("R10 lengths", {ph_len[0][7:0], ph_len[1][7:0]}, 16'h0202);
    chk("R10 lanes", {ph_ble[0], ph_bhe[0], ph_ble[1], ph_bhe[1]}, 4'b0101);
    chk("R10 pin", ph_cs[1], 6'h04);
    chk("R10 read assembly", rd, {mem_word(24'h500041) & 16'h00FF} << 8 | (mem_word(24'h500040) & 16'h00FF));
    access(1, 24'h500060, 2'b11, 16'h1234, 0);
    chk("R10 write low byte first", ph_dout[0][7:0], 8'h34);
    chk("R10 write high byte second", ph_dout[1][7:0], 8'h12);
    chk("R10 write strobes", {ph_we[0], ph_we[1]}, 2'b00);
  endtask

  task automatic t_odd_byte();
    access(0, 24'h500050, 2'b10, 0, 0);
    chk("R12 one phase", ph_n, 1);
    chk("R12 odd address", ph_addr[0], 24'h500051);
    chk("R12 low lane", {ph_ble[0], ph_bhe[0]}, 2'b01);
    chk("R12 data high", rd, {mem_word(24'h500051) & 16'h00FF} << 8);
  endtask

  task automatic t_wait();
    access(0, 24'h300000, 2'b11, 0, 5);
    chk("R8 wait extends", ph_len[0], 5);
    access(0, 24'h300000, 2'b11, 0, 2);
    chk("R8 wait inside count", ph_len[0], 3);
  endtask

  task automatic t_swap();
    cfg(3'd6, 16'h0001);
    access(0, 24'h000200, 2'b11, 0, 0);
    chk("R6 boot on pin1", ph_cs[0], 6'h02);
    chk("R6 boot timing kept", ph_len[0], 16);
    access(0, 24'h300000, 2'b11, 0, 0);
    chk("R6 slot1 on pin0", ph_cs[0], 6'h01);
    access(0, 24'h500000, 2'b01, 0, 0);
    chk("R6 slot2 unchanged", ph_cs[0], 6'h04);
  endtask

  task automatic t_narrow_boot();
    do_reset(1'b0);
    access(0, 24'h000010, 2'b11, 0, 0);
    chk("R2 8-bit boot split", ph_n, 2);
    chk("R1 swap cleared", ph_cs[0], 6'h01);
    chk("R2 8-bit boot data", rd, {mem_word(24'h000011) & 16'h00FF} << 8 | (mem_word(24'h000010) & 16'h00FF));
    access(0, 24'h300000, 2'b11, 0, 0);
    chk("R1 slot1 disabled", ph_cs[0], 6'h00);
    cfg(3'd0, 16'h0030);
    access(0, 24'h000010, 2'b11, 0, 0);
    chk("R2 R3 width written", ph_n, 1);
    chk("R3 ws0 length", ph_len[0], 1);
    chk("R3 data", rd, mem_word(24'h000010));
    cfg(3'd0, 16'h0010);
    access(0, 24'h000010, 2'b11, 0, 0);
    chk("R3 disabled slot no pin", ph_cs[0], 6'h00);
    chk("R3 disabled slot ones", rd, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog (R8) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_boot_read();
    t_unmapped();
    t_slot1_byte();
    t_slot1_write();
    t_priority();
    t_narrow();
    t_odd_byte();
    t_wait();
    t_swap();
    t_narrow_boot();
    repeat (2) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule